// File: doc/BRIEF.md
# Guest Exit Intercept Decision Unit

This unit decides, for each event raised while a guest runs, whether that event must hand control back to the hypervisor. When the guest is entered, a load strobe captures a set of intercept masks. These are a 64-bit general vector, separate 16-bit masks for control-register reads, control-register writes, debug-register reads and debug-register writes, and a 32-bit exception mask. Each later query gives an exit-type code, a 64-bit parameter and the current model-specific register (MSR) index. The unit answers with a one-cycle exit request that carries the code and the parameter.

Most codes are resolved in one cycle by a bit test against the mask that covers the code's window. A query with the MSR-access code is different. Its index is mapped into one of three index windows of a permission bitmap, which holds two bits per register: one for reads and one for writes. The unit issues a one-byte read of that bitmap over a valid/ready request channel. It stays busy until the byte returns, then tests the selected bit. An index that falls outside all windows exits at once, with no read. Carrying out the exit and saving guest state are handled elsewhere.

With the default parameters the code map is as follows. Control-register reads are codes 0..8 and writes are 16..24. Debug-register reads are 32..39 and writes are 48..55. Exceptions are 64..95. The general vector covers codes 96..159, and its bit 28 (code 124) is the MSR-access code.

Top module: `guest_trap_judge`

## Requirements
- R1: While `trap_on` is low at acceptance, a query never produces an exit and never issues a bitmap read.
- R2: A code in 0..8 exits iff bit (code) of the control-read mask is set. A code in 16..24 exits iff bit (code−16) of the control-write mask is set. Codes 9..15 and 25..31 never exit.
- R3: A code in 32..39 exits iff bit (code−32) of the debug-read mask is set. A code in 48..55 exits iff bit (code−48) of the debug-write mask is set. Mask bits 8..15 are never consulted.
- R4: A code in 64..95 exits iff bit (code−64) of the exception mask is set.
- R5: Any other code in 96..159 exits iff bit (code−96) of the general vector is set. Codes of 160 and above never exit.
- R6: A query with code 124 while bit 28 of the general vector is clear does not exit and issues no bitmap read.
- R7: With bit 28 set, an MSR index in 0..0x1FFF gets bit offset 2×index. An index in 0xC0000000..0xC0001FFF gets 2×(8192+index−0xC0000000). An index in 0xC0010000..0xC0011FFF gets 2×(16384+index−0xC0010000). One read is issued at byte address offset/8. The query exits iff bit (offset mod 8)+param[0] of the returned byte is set, where param[0]=0 means a read access and 1 means a write access.
- R8: With bit 28 set, an MSR index outside the three windows exits without any bitmap read.
- R9: `mem_req_valid` stays high with a stable `mem_addr` until `mem_req_ready`. `busy` is high from the accepted MSR query until the response arrives. Queries presented while `busy` is high are ignored.
- R10: An exit is a one-cycle `exit_pulse` with `exit_code` and `exit_param` equal to the query's code and parameter. It comes one cycle after acceptance, or one cycle after the response for a bitmap lookup.
- R11: After reset, `busy`, `exit_pulse` and `mem_req_valid` are low and all masks are zero, so no query exits until a load.
- R12: A later load strobe replaces every captured mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_on | input | 1 | Intercepts enabled |
| load_en | input | 1 | Capture strobe for all masks |
| load_gen | input | 64 | General intercept vector |
| load_cr_rd | input | 16 | Control-register read mask |
| load_cr_wr | input | 16 | Control-register write mask |
| load_dr_rd | input | 16 | Debug-register read mask |
| load_dr_wr | input | 16 | Debug-register write mask |
| load_exc | input | 32 | Exception mask |
| q_valid | input | 1 | Query present |
| q_code | input | 32 | Exit-type code |
| q_param | input | 64 | Query parameter (bit 0 = write access for MSR) |
| q_msr | input | 32 | Current MSR index |
| busy | output | 1 | Bitmap lookup in progress; queries ignored |
| mem_req_valid | output | 1 | Bitmap byte read request |
| mem_req_ready | input | 1 | Request accepted |
| mem_addr | output | 13 | Bitmap byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 8 | Bitmap byte |
| exit_pulse | output | 1 | One-cycle exit request |
| exit_code | output | 32 | Code of the exiting query |
| exit_param | output | 64 | Parameter of the exiting query |

## Verification
The assertions assume three things about the memory side. A bitmap response arrives only after its request has been accepted, and never in the same cycle as that acceptance. At most one response comes per request. For MSR queries, only bit 0 of the parameter is meaningful. The bench's responder model keeps to this. It raises ready after a random wait, then returns exactly one byte one to three cycles later, computed from the address. MSR queries in the bench use parameters 0 or 1 only, while other codes get random 64-bit parameters.

// File: rtl/gtj_pkg.sv
package gtj_pkg;
   localparam int GEN_W = 64;
   localparam int REG_MASK_W = 16;
   localparam int EXC_W = 32;

   localparam int MSR_WINDOWS = 3;
   localparam int unsigned MSR_SPAN = 8192;
   localparam int SPAN_W = $clog2(MSR_SPAN);
   localparam logic [31:0] MSR_LO [MSR_WINDOWS] = '{32'h0000_0000, 32'hC000_0000, 32'hC001_0000};
   localparam int unsigned MSR_SLOT [MSR_WINDOWS] = '{0, 8192, 16384};
   localparam int OFF_W = $clog2((MSR_SLOT[MSR_WINDOWS-1] + MSR_SPAN) * 2);
   localparam int BA_W = OFF_W - 3;

   typedef struct packed {
      logic [GEN_W-1:0]      gen;
      logic [REG_MASK_W-1:0] cr_rd;
      logic [REG_MASK_W-1:0] cr_wr;
      logic [REG_MASK_W-1:0] dr_rd;
      logic [REG_MASK_W-1:0] dr_wr;
      logic [EXC_W-1:0]      exc;
   } gtj_masks_t;

   typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} gtj_state_e;
endpackage

// File: rtl/gtj_window_bit.sv
module gtj_window_bit #(
   parameter int unsigned BASE = 0,
   parameter int unsigned SPAN = 8,
   parameter int W = 16
) (
   input  logic [31:0]  code,
   input  logic [W-1:0] mask,
   output logic         in_win,
   output logic         hit
);
   localparam int IW = (W > 1) ? $clog2(W) : 1;

   generate
      if (SPAN == 0 || SPAN > W) begin : g_bad_span
         $error("gtj_window_bit: SPAN must be 1..W");
      end
   endgenerate

   logic [31:0] diff;

   always_comb begin
      diff   = code - BASE;
      in_win = (diff < SPAN);
      hit    = in_win & mask[diff[IW-1:0]];
   end
endmodule

// File: rtl/gtj_mask_select.sv
module gtj_mask_select import gtj_pkg::*; #(
   parameter int unsigned CR_RD_BASE = 0,
   parameter int unsigned CR_WR_BASE = 16,
   parameter int unsigned DR_RD_BASE = 32,
   parameter int unsigned DR_WR_BASE = 48,
   parameter int unsigned EXC_BASE   = 64,
   parameter int unsigned GEN_BASE   = 96,
   parameter int unsigned CR_SPAN    = 9,
   parameter int unsigned DR_SPAN    = 8
) (
   input  logic [31:0] code,
   input  gtj_masks_t  masks,
   output logic        hit
);
   logic w_crr, w_crw, w_drr, w_drw, w_exc, w_gen;
   logic h_crr, h_crw, h_drr, h_drw, h_exc, h_gen;

   gtj_window_bit #(.BASE(CR_RD_BASE), .SPAN(CR_SPAN), .W(REG_MASK_W)) u_crr (
      .code(code), .mask(masks.cr_rd), .in_win(w_crr), .hit(h_crr));
   gtj_window_bit #(.BASE(CR_WR_BASE), .SPAN(CR_SPAN), .W(REG_MASK_W)) u_crw (
      .code(code), .mask(masks.cr_wr), .in_win(w_crw), .hit(h_crw));
   gtj_window_bit #(.BASE(DR_RD_BASE), .SPAN(DR_SPAN), .W(REG_MASK_W)) u_drr (
      .code(code), .mask(masks.dr_rd), .in_win(w_drr), .hit(h_drr));
   gtj_window_bit #(.BASE(DR_WR_BASE), .SPAN(DR_SPAN), .W(REG_MASK_W)) u_drw (
      .code(code), .mask(masks.dr_wr), .in_win(w_drw), .hit(h_drw));
   gtj_window_bit #(.BASE(EXC_BASE), .SPAN(EXC_W), .W(EXC_W)) u_exc (
      .code(code), .mask(masks.exc), .in_win(w_exc), .hit(h_exc));
   gtj_window_bit #(.BASE(GEN_BASE), .SPAN(GEN_W), .W(GEN_W)) u_gen (
      .code(code), .mask(masks.gen), .in_win(w_gen), .hit(h_gen));

   always_comb begin
      if (w_crr)      hit = h_crr;
      else if (w_crw) hit = h_crw;
      else if (w_drr) hit = h_drr;
      else if (w_drw) hit = h_drw;
      else if (w_exc) hit = h_exc;
      else if (w_gen) hit = h_gen;
      else            hit = 1'b0;
   end
endmodule

// File: rtl/gtj_msr_map.sv
module gtj_msr_map import gtj_pkg::*; (
   input  logic [31:0]     msr_idx,
   input  logic            is_write,
   output logic            in_win,
   output logic [BA_W-1:0] byte_addr,
   output logic [2:0]      bit_sel
);
   logic [MSR_WINDOWS-1:0] win_hit;
   logic [OFF_W-1:0]       win_off [MSR_WINDOWS];
   logic [OFF_W-1:0]       off;

   generate
      for (genvar i = 0; i < MSR_WINDOWS; i++) begin : g_win
         logic [31:0] d;
         assign d          = msr_idx - MSR_LO[i];
         assign win_hit[i] = (d < MSR_SPAN);
         assign win_off[i] = (OFF_W'(MSR_SLOT[i]) + OFF_W'(d[SPAN_W-1:0])) << 1;
      end
   endgenerate

   always_comb begin
      off    = '0;
      in_win = 1'b0;
      for (int i = MSR_WINDOWS - 1; i >= 0; i--) begin
         if (win_hit[i]) begin
            off    = win_off[i];
            in_win = 1'b1;
         end
      end
      byte_addr = off[OFF_W-1:3];
      bit_sel   = {off[2:1], off[0] | is_write};
   end
endmodule

// File: rtl/guest_trap_judge.sv
module guest_trap_judge import gtj_pkg::*; #(
   parameter int unsigned CR_RD_BASE = 0,
   parameter int unsigned CR_WR_BASE = 16,
   parameter int unsigned DR_RD_BASE = 32,
   parameter int unsigned DR_WR_BASE = 48,
   parameter int unsigned EXC_BASE   = 64,
   parameter int unsigned GEN_BASE   = 96,
   parameter int unsigned MSR_CODE   = 124,
   parameter int unsigned CR_SPAN    = 9,
   parameter int unsigned DR_SPAN    = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  trap_on,
   input  logic                  load_en,
   input  logic [GEN_W-1:0]      load_gen,
   input  logic [REG_MASK_W-1:0] load_cr_rd,
   input  logic [REG_MASK_W-1:0] load_cr_wr,
   input  logic [REG_MASK_W-1:0] load_dr_rd,
   input  logic [REG_MASK_W-1:0] load_dr_wr,
   input  logic [EXC_W-1:0]      load_exc,
   input  logic                  q_valid,
   input  logic [31:0]           q_code,
   input  logic [63:0]           q_param,
   input  logic [31:0]           q_msr,
   output logic                  busy,
   output logic                  mem_req_valid,
   input  logic                  mem_req_ready,
   output logic [BA_W-1:0]       mem_addr,
   input  logic                  mem_rsp_valid,
   input  logic [7:0]            mem_rsp_data,
   output logic                  exit_pulse,
   output logic [31:0]           exit_code,
   output logic [63:0]           exit_param
);
   localparam int MSR_BIT = MSR_CODE - GEN_BASE;

   generate
      if (MSR_CODE < GEN_BASE || MSR_CODE >= GEN_BASE + GEN_W) begin : g_bad_msr
         $error("guest_trap_judge: MSR_CODE must fall in the general window");
      end
   endgenerate

   gtj_masks_t masks;
   gtj_state_e state;
   logic [2:0] bit_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         masks <= '0;
      end else if (load_en) begin
         masks <= '{gen: load_gen, cr_rd: load_cr_rd, cr_wr: load_cr_wr,
                    dr_rd: load_dr_rd, dr_wr: load_dr_wr, exc: load_exc};
      end
   end

   logic            plain_hit;
   logic            msr_in;
   logic [BA_W-1:0] msr_addr;
   logic [2:0]      msr_bit;

   gtj_mask_select #(
      .CR_RD_BASE(CR_RD_BASE), .CR_WR_BASE(CR_WR_BASE),
      .DR_RD_BASE(DR_RD_BASE), .DR_WR_BASE(DR_WR_BASE),
      .EXC_BASE(EXC_BASE), .GEN_BASE(GEN_BASE),
      .CR_SPAN(CR_SPAN), .DR_SPAN(DR_SPAN)
   ) u_sel (
      .code(q_code), .masks(masks), .hit(plain_hit));

   gtj_msr_map u_map (
      .msr_idx(q_msr), .is_write(q_param[0]), .in_win(msr_in),
      .byte_addr(msr_addr), .bit_sel(msr_bit));

   logic acc, is_msr, msr_gate;
   assign busy          = (state != ST_IDLE);
   assign acc           = q_valid && !busy;
   assign is_msr        = (q_code == MSR_CODE);
   assign msr_gate      = masks.gen[MSR_BIT];
   assign mem_req_valid = (state == ST_ISSUE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         exit_pulse <= 1'b0;
         exit_code  <= '0;
         exit_param <= '0;
         mem_addr   <= '0;
         bit_q      <= '0;
      end else begin
         exit_pulse <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (acc) begin
                  exit_code  <= q_code;
                  exit_param <= q_param;
                  if (!trap_on) begin
                     exit_pulse <= 1'b0;
                  end else if (is_msr) begin
                     if (msr_gate && !msr_in) begin
                        exit_pulse <= 1'b1;
                     end else if (msr_gate) begin
                        state    <= ST_ISSUE;
                        mem_addr <= msr_addr;
                        bit_q    <= msr_bit;
                     end
                  end else begin
                     exit_pulse <= plain_hit;
                  end
               end
            end
            ST_ISSUE: begin
               if (mem_req_ready) state <= ST_WAIT;
            end
            ST_WAIT: begin
               if (mem_rsp_valid) begin
                  exit_pulse <= mem_rsp_data[bit_q];
                  state      <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R1: disabled intercepts give neither an exit nor a lookup
   assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !trap_on) |=> (!exit_pulse && !busy));

   // R6: MSR code with its general bit clear stays silent
   assert_msr_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && trap_on && is_msr && !msr_gate) |=> (!exit_pulse && !busy));

   // R8: out-of-window index exits at once without a read
   assert_msr_outside_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && trap_on && is_msr && msr_gate && !msr_in) |=> (exit_pulse && !mem_req_valid));

   // R9: request held with a stable address until accepted
   assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr)));

   // R9: busy persists until the response returns
   assert_busy_until_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !mem_rsp_valid) |=> busy);
endmodule

// File: tb/sim_guest_trap_judge.sv
module sim_guest_trap_judge;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n, trap_on, load_en;
   logic [63:0] load_gen;
   logic [15:0] load_cr_rd, load_cr_wr, load_dr_rd, load_dr_wr;
   logic [31:0] load_exc;
   logic        q_valid;
   logic [31:0] q_code, q_msr;
   logic [63:0] q_param;
   logic        busy, mem_req_valid, mem_req_ready, mem_rsp_valid;
   logic [12:0] mem_addr;
   logic [7:0]  mem_rsp_data;
   logic        exit_pulse;
   logic [31:0] exit_code;
   logic [63:0] exit_param;

   guest_trap_judge u0 (
      .clk(clk), .rst_n(rst_n), .trap_on(trap_on), .load_en(load_en),
      .load_gen(load_gen), .load_cr_rd(load_cr_rd), .load_cr_wr(load_cr_wr),
      .load_dr_rd(load_dr_rd), .load_dr_wr(load_dr_wr), .load_exc(load_exc),
      .q_valid(q_valid), .q_code(q_code), .q_param(q_param), .q_msr(q_msr),
      .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .exit_pulse(exit_pulse), .exit_code(exit_code), .exit_param(exit_param));

   int checks = 0, errors = 0, hs_count = 0, pulses = 0;
   logic [12:0] last_addr;
   logic [63:0] m_gen;
   logic [15:0] m_crr, m_crw, m_drr, m_drw;
   logic [31:0] m_exc;

   function automatic logic [7:0] bmp(input int unsigned a);
      return 8'((a * 37 + 11) ^ (a >> 3));
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // bitmap responder
   always @(posedge clk) if (mem_req_valid && mem_req_ready) begin
      hs_count++;
      last_addr = mem_addr;
   end
   always @(negedge clk) if (exit_pulse) pulses++;

   initial begin
      mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
      forever begin
         @(negedge clk);
         if (mem_req_valid) begin
            logic [12:0] a;
            repeat ($urandom % 3) @(negedge clk);
            mem_req_ready = 1;
            a = mem_addr;
            @(negedge clk);
            mem_req_ready = 0;
            repeat ($urandom % 3) @(negedge clk);
            mem_rsp_valid = 1;
            mem_rsp_data = bmp(a);
            @(negedge clk);
            mem_rsp_valid = 0;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   function automatic void model(input logic en, input logic [31:0] code, input logic [63:0] prm,
                                 input logic [31:0] msr, output logic ex, output logic mem,
                                 output int unsigned addr);
      int unsigned off;
      logic inw;
      logic [7:0] b;
      ex = 0; mem = 0; addr = 0;
      if (!en) return;
      if (code <= 8) ex = m_crr[code];
      else if (code >= 16 && code <= 24) ex = m_crw[code-16];
      else if (code >= 32 && code <= 39) ex = m_drr[code-32];
      else if (code >= 48 && code <= 55) ex = m_drw[code-48];
      else if (code >= 64 && code <= 95) ex = m_exc[code-64];
      else if (code == 124) begin
         if (m_gen[28]) begin
            inw = 1; off = 0;
            if (msr < 32'h2000) off = msr * 2;
            else if (msr >= 32'hC000_0000 && msr <= 32'hC000_1FFF) off = (8192 + msr - 32'hC000_0000) * 2;
            else if (msr >= 32'hC001_0000 && msr <= 32'hC001_1FFF) off = (16384 + msr - 32'hC001_0000) * 2;
            else inw = 0;
            if (!inw) ex = 1;
            else begin
               mem = 1; addr = off / 8;
               b = bmp(addr);
               ex = b[(off % 8) + prm[0]];
            end
         end
      end
      else if (code >= 96 && code <= 159) ex = m_gen[code-96];
   endfunction

   task automatic do_load(input logic [63:0] g, input logic [15:0] a, input logic [15:0] b,
                          input logic [15:0] c, input logic [15:0] d, input logic [31:0] e);
      @(negedge clk);
      load_en = 1; load_gen = g; load_cr_rd = a; load_cr_wr = b;
      load_dr_rd = c; load_dr_wr = d; load_exc = e;
      @(negedge clk);
      load_en = 0;
      m_gen = g; m_crr = a; m_crw = b; m_drr = c; m_drw = d; m_exc = e;
   endtask

   task automatic query(input logic en, input logic [31:0] code, input logic [63:0] prm,
                        input logic [31:0] msr, input string tag);
      logic ex, mem;
      int unsigned addr;
      int hs0, p0, n;
      model(en, code, prm, msr, ex, mem, addr);
      hs0 = hs_count; p0 = pulses;
      @(negedge clk);
      trap_on = en; q_valid = 1; q_code = code; q_param = prm; q_msr = msr;
      @(negedge clk);
      q_valid = 0;
      n = 0;
      while (busy && n < 50) begin @(negedge clk); n++; end
      check(exit_pulse == ex, tag, "exit decision", 64'(exit_pulse), 64'(ex));
      if (ex) begin
         check(exit_code == code, "R10", "exit_code", 64'(exit_code), 64'(code));
         check(exit_param == prm, "R10", "exit_param", exit_param, prm);
      end
      check((hs_count - hs0) == (mem ? 1 : 0), tag, "bitmap reads", 64'(hs_count - hs0), 64'(mem));
      if (mem) check(last_addr == 13'(addr), "R7", "byte address", 64'(last_addr), 64'(addr));
      @(negedge clk);
      #1;
      check(!exit_pulse && (pulses - p0) == (ex ? 1 : 0), "R10", "pulse count",
            64'(pulses - p0), 64'(ex));
   endtask

   function automatic logic [31:0] pick_msr();
      case ($urandom % 6)
         0: return $urandom % 32'h2000;
         1: return 32'hC000_0000 + ($urandom % 32'h2000);
         2: return 32'hC001_0000 + ($urandom % 32'h2000);
         3: return 32'h2000 + ($urandom % 1000);
         4: return 32'hC000_2000 + ($urandom % 100);
         default: return $urandom;
      endcase
   endfunction

   function automatic string msr_tag(input logic [31:0] m);
      if (!m_gen[28]) return "R6";
      if (m < 32'h2000 || (m >= 32'hC000_0000 && m <= 32'hC000_1FFF) ||
          (m >= 32'hC001_0000 && m <= 32'hC001_1FFF)) return "R7";
      return "R8";
   endfunction

   initial begin
      void'($urandom(32'd4242));
      rst_n = 0; trap_on = 0; load_en = 0; q_valid = 0;
      q_code = 0; q_param = 0; q_msr = 0;
      load_gen = 0; load_cr_rd = 0; load_cr_wr = 0; load_dr_rd = 0; load_dr_wr = 0; load_exc = 0;
      m_gen = 0; m_crr = 0; m_crw = 0; m_drr = 0; m_drw = 0; m_exc = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R11 reset state
      check(!busy && !exit_pulse && !mem_req_valid, "R11", "reset outputs",
            64'({busy, exit_pulse, mem_req_valid}), 64'd0);
      query(1, 32'd96, 64'h5, 32'd0, "R11");
      query(1, 32'd0, 64'h1, 32'd0, "R11");

      // directed boundaries
      do_load(64'h8000_0000_1000_0001, 16'h0100, 16'h0100, 16'hFF80, 16'h0001, 32'h8000_0001);
      query(1, 32'd8, 64'h11, 0, "R2");
      query(1, 32'd9, 64'h12, 0, "R2");
      query(1, 32'd24, 64'h13, 0, "R2");
      query(1, 32'd39, 64'h14, 0, "R3");
      query(1, 32'd40, 64'h15, 0, "R3");
      query(1, 32'd48, 64'h16, 0, "R3");
      query(1, 32'd95, 64'h17, 0, "R4");
      query(1, 32'd64, 64'h18, 0, "R4");
      query(1, 32'd159, 64'h19, 0, "R5");
      query(1, 32'd160, 64'h1A, 0, "R5");
      query(0, 32'd8, 64'h1B, 0, "R1");
      query(0, 32'd124, 64'h0, 32'h10, "R1");
      query(1, 32'd124, 64'h0, 32'h1FFF, "R7");
      query(1, 32'd124, 64'h1, 32'h2000, "R8");
      query(1, 32'd124, 64'h1, 32'hC001_1FFF, "R7");
      query(1, 32'd124, 64'h0, 32'hC001_2000, "R8");
      query(1, 32'd124, 64'h1, 32'hC000_0000, "R7");

      // R9: a query offered while busy is dropped
      begin
         int p0;
         p0 = pulses;
         @(negedge clk);
         trap_on = 1; q_valid = 1; q_code = 124; q_param = 0; q_msr = 32'h40;
         @(negedge clk);
         check(busy == 1, "R9", "busy after lookup start", 64'(busy), 64'd1);
         q_code = 8; q_param = 64'hDEAD;
         @(negedge clk);
         q_valid = 0;
         while (busy) @(negedge clk);
         @(negedge clk);
         #1;
         check((pulses - p0) == int'(bmp(32'h40 * 2 / 8)[0]), "R9", "pulses with rejected query",
               64'(pulses - p0), 64'(bmp(32'h40 * 2 / 8)[0]));
         check(exit_code == 124, "R9", "code not overwritten", 64'(exit_code), 64'd124);
      end

      // R12: reload replaces masks
      do_load(64'h0, 16'h0, 16'h0, 16'h0, 16'h0, 32'h0);
      query(1, 32'd8, 64'h21, 0, "R12");
      query(1, 32'd124, 64'h0, 32'h2000, "R12");

      // random mix
      for (int r = 0; r < 8; r++) begin
         logic [63:0] g;
         g = {$urandom, $urandom};
         g[28] = ($urandom % 4 != 0);
         do_load(g, 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), $urandom);
         for (int k = 0; k < 40; k++) begin
            logic [31:0] c, m;
            logic [63:0] p;
            logic en;
            string tg;
            en = ($urandom % 10 != 0);
            p = {$urandom, $urandom};
            m = pick_msr();
            case ($urandom % 8)
               0: begin c = $urandom % 9; tg = "R2"; end
               1: begin c = 16 + $urandom % 9; tg = "R2"; end
               2: begin c = 32 + $urandom % 8; tg = "R3"; end
               3: begin c = 48 + $urandom % 8; tg = "R3"; end
               4: begin c = 64 + $urandom % 32; tg = "R4"; end
               5: begin c = 96 + $urandom % 64; tg = "R5"; end
               6: begin c = $urandom % 256; tg = "R5"; end
               default: begin c = 124; tg = "R7"; end
            endcase
            if (c == 124) begin p = 64'($urandom % 2); tg = msr_tag(m); end
            if (!en) tg = "R1";
            query(en, c, p, m, tg);
         end
      end
      finish_run();
   end
endmodule